// File: doc/BRIEF.md
# Real-Time-Clock Interrupt Request Combiner

This block sits behind a real-time clock and gathers three single-cycle event pulses: the alarm match, the periodic tick and the update-ended notice. It merges them into one active-low interrupt request line. Each source owns a sticky flag that is set whenever its event fires, whether or not the source is enabled. Software can therefore poll a flag without taking the interrupt. A separate enable register, written by the host, selects which flags may pull the request line low.

The host reaches the block through a small synchronous register port with a one-bit address. Address 0 is the enable register and address 1 is the status register. A read is a one-cycle strobe. The value read is captured into a holding register and stays on `rd_data` until the next strobe. A status read clears every flag it reported. An event that lands in the same cycle as the strobe is not shown in that read and is not erased: it appears as a set flag once the clear has taken effect. Bit 7 of the status word is a summary bit that mirrors the request line.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset all flags and enables are 0, `irq_n` is 1 and `rd_data` is 0x00.
- R2: An event pulse sets its flag on the following clock edge whatever the state of its enable bit.
- R3: `irq_n` is 0 exactly while at least one source has both its flag and its enable bit set, and is 1 otherwise.
- R4: Enabling a source whose flag is already set drives `irq_n` low in the cycle after the enable write, although the event happened earlier.
- R5: A status read strobe loads `rd_data` on the next edge with bit 7 = summary, bit 6 = periodic flag, bit 5 = alarm flag, bit 4 = update-ended flag and bits 3..0 = 0. `rd_data` then holds until the next read strobe.
- R6: A status read clears every flag that was 1 in the strobe cycle, effective from the cycle after the strobe.
- R7: An event arriving in the strobe cycle of a status read is not reported by that read, and its flag reads 1 from the cycle after the strobe.
- R8: A write to address 0 loads enables from `wr_data` bit 6 (periodic), bit 5 (alarm) and bit 4 (update-ended). Other bits are ignored. A read of address 0 returns the enables in those positions with all other bits 0, and it does not change the flags.
- R9: The summary bit returned by a status read equals the inverse of `irq_n` in the strobe cycle.
- R10: A write to address 1 changes neither the flags nor the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_alarm | input | 1 | One-cycle alarm-match event |
| evt_periodic | input | 1 | One-cycle periodic-tick event |
| evt_update | input | 1 | One-cycle update-ended event |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 = enables, 1 = status (ignored) |
| wr_data | input | 8 | Write data |
| rd_stb | input | 1 | One-cycle read strobe |
| rd_addr | input | 1 | Read address: 0 = enables, 1 = status |
| rd_data | output | 8 | Read data, held from the cycle after a strobe |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
On every cycle the checker verifies several properties. An event always leaves its flag set on the next edge, and a status read leaves exactly the events of the strobe cycle behind. The flags and enables stay put when nothing acts on them. The held read data only moves after a strobe, and the summary bit tracks the request line. Other behaviour can only be shown by the bench's scenarios, because it depends on the exact encoded values that come back through the read port. This includes the bit layout of both registers and the ignoring of reserved write bits. It also covers a late enable acting on an old flag and the full reset state seen through reads.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int NUM_SRC  = 3;
  localparam int DATA_W   = 8;
  localparam int FLAG_LSB = 4;
  localparam int IRQF_BIT = DATA_W - 1;

  // source index order matches bit order above FLAG_LSB
  localparam int SRC_UPDATE   = 0;
  localparam int SRC_ALARM    = 1;
  localparam int SRC_PERIODIC = 2;

  localparam logic ADDR_ENABLE = 1'b0;
  localparam logic ADDR_STATUS = 1'b1;

  typedef logic [NUM_SRC-1:0] src_vec_t;
  typedef logic [DATA_W-1:0]  word_t;

  function automatic word_t place_sources(input src_vec_t v);
    word_t w;
    w = '0;
    w[FLAG_LSB +: NUM_SRC] = v;
    return w;
  endfunction

  function automatic word_t pack_status(input src_vec_t flags, input logic summary);
    word_t w;
    w = place_sources(flags);
    w[IRQF_BIT] = summary;
    return w;
  endfunction

  function automatic src_vec_t pick_sources(input word_t w);
    return w[FLAG_LSB +: NUM_SRC];
  endfunction

  function automatic logic any_active(input src_vec_t flags, input src_vec_t en);
    return |(flags & en);
  endfunction
endpackage

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
  import rtc_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t evt,
  input  logic     clr_stb,
  output src_vec_t flags,
  output src_vec_t deferred
);
  src_vec_t flag_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic read_mask;
    assign read_mask   = clr_stb & flag_q[i];
    assign deferred[i] = clr_stb & evt[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[i] <= 1'b0;
      end else begin
        flag_q[i] <= (flag_q[i] & ~read_mask) | evt[i];
      end
    end
  end

  assign flags = flag_q;
endmodule

// File: rtl/rtc_irq_enables.sv
module rtc_irq_enables
  import rtc_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     we,
  input  src_vec_t wvalue,
  output src_vec_t en
);
  src_vec_t en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (we) begin
      en_q <= wvalue;
    end
  end

  assign en = en_q;
endmodule

// File: rtl/rtc_irq_regport.sv
module rtc_irq_regport
  import rtc_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  logic     wr_addr,
  input  word_t    wr_data,
  input  logic     rd_stb,
  input  logic     rd_addr,
  input  src_vec_t flags,
  input  src_vec_t en,
  input  logic     irq_req,
  output logic     en_we,
  output src_vec_t en_wvalue,
  output logic     status_rd,
  output word_t    rd_data
);
  word_t rd_q;
  word_t rd_next;

  assign en_we     = wr_en & (wr_addr == ADDR_ENABLE);
  assign en_wvalue = pick_sources(wr_data);
  assign status_rd = rd_stb & (rd_addr == ADDR_STATUS);

  always_comb begin
    if (rd_addr == ADDR_STATUS) begin
      rd_next = pack_status(flags, irq_req);
    end else begin
      rd_next = place_sources(en);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_stb) begin
      rd_q <= rd_next;
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_alarm,
  input  logic       evt_periodic,
  input  logic       evt_update,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_stb,
  input  logic       rd_addr,
  output logic [7:0] rd_data,
  output logic       irq_n
);
  src_vec_t evt_vec;
  src_vec_t flag_vec;
  src_vec_t en_vec;
  src_vec_t deferred_vec;
  src_vec_t en_wvalue;
  logic     en_we;
  logic     status_rd;
  logic     irq_req;

  always_comb begin
    evt_vec               = '0;
    evt_vec[SRC_UPDATE]   = evt_update;
    evt_vec[SRC_ALARM]    = evt_alarm;
    evt_vec[SRC_PERIODIC] = evt_periodic;
  end

  rtc_irq_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_vec),
    .clr_stb  (status_rd),
    .flags    (flag_vec),
    .deferred (deferred_vec)
  );

  rtc_irq_enables u_en (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (en_we),
    .wvalue (en_wvalue),
    .en     (en_vec)
  );

  assign irq_req = any_active(flag_vec, en_vec);
  assign irq_n   = ~irq_req;

  rtc_irq_regport u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_stb    (rd_stb),
    .rd_addr   (rd_addr),
    .flags     (flag_vec),
    .en        (en_vec),
    .irq_req   (irq_req),
    .en_we     (en_we),
    .en_wvalue (en_wvalue),
    .status_rd (status_rd),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/rtc_irq_ctrl_chk.sv
module rtc_irq_ctrl_chk
  import rtc_irq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input src_vec_t   evt,
  input src_vec_t   flags,
  input src_vec_t   enables,
  input src_vec_t   deferred,
  input logic       wr_en,
  input logic       wr_addr,
  input logic [7:0] wr_data,
  input logic       rd_stb,
  input logic       rd_addr,
  input logic [7:0] rd_data,
  input logic       irq_n
);
  p_evt_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));

  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_addr == ADDR_STATUS && evt == '0) |=> (flags == '0));

  p_deferred_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_addr == ADDR_STATUS) |=> (flags == $past(deferred)));

  p_late_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_ENABLE && ((flags & wr_data[FLAG_LSB +: NUM_SRC]) != '0)
     && !(rd_stb && rd_addr == ADDR_STATUS)) |=> !irq_n);

  p_summary_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_addr == ADDR_STATUS) |=> (rd_data[IRQF_BIT] == !$past(irq_n)));

  p_rd_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));

  p_flags_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!(rd_stb && rd_addr == ADDR_STATUS) && evt == '0) |=> $stable(flags));

  p_status_write_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && wr_addr == ADDR_ENABLE)) |=> $stable(enables));
endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .evt      (evt_vec),
  .flags    (flag_vec),
  .enables  (en_vec),
  .deferred (deferred_vec),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .rd_stb   (rd_stb),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data),
  .irq_n    (irq_n)
);

// File: tb/test_rtc_irq_ctrl.sv
module test_rtc_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  // evt field: bit2 periodic, bit1 alarm, bit0 update-ended
  typedef struct packed {
    logic       we;
    logic       waddr;
    logic [7:0] wdata;
    logic       rs;
    logic       raddr;
    logic [2:0] evt;
    logic       exp_irq_n;
    logic [7:0] exp_rd;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 3'b100, 1'b1, 8'h00}, // periodic event, not enabled
    '{1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 3'b000, 1'b1, 8'h40}, // status read
    '{1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 3'b000, 1'b1, 8'h40}, // idle, data held
    '{1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 3'b010, 1'b1, 8'h40}, // alarm event
    '{1'b1, 1'b0, 8'hFF, 1'b0, 1'b0, 3'b000, 1'b0, 8'h40}, // enable all, late enable
    '{1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 3'b000, 1'b0, 8'h70}, // read enables
    '{1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 3'b000, 1'b1, 8'hA0}, // status read clears
    '{1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 3'b001, 1'b0, 8'h00}, // update during read
    '{1'b1, 1'b0, 8'h40, 1'b0, 1'b0, 3'b000, 1'b1, 8'h00}, // enable periodic only
    '{1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 3'b100, 1'b0, 8'h00}, // periodic event
    '{1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 3'b000, 1'b0, 8'h00}, // write to status ignored
    '{1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 3'b000, 1'b1, 8'hD0}, // status read
    '{1'b1, 1'b0, 8'h0F, 1'b0, 1'b0, 3'b000, 1'b1, 8'hD0}, // reserved bits only
    '{1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 3'b000, 1'b1, 8'h00}  // enables read as zero
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_alarm = 1'b0, evt_periodic = 1'b0, evt_update = 1'b0;
  logic       wr_en = 1'b0, wr_addr = 1'b0, rd_stb = 1'b0, rd_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq_n;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_irq_ctrl i_rtc_irq_ctrl (
    .clk(clk), .rst_n(rst_n),
    .evt_alarm(evt_alarm), .evt_periodic(evt_periodic), .evt_update(evt_update),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive at negedge, let one edge pass, sample a quarter period later
  task automatic step(input logic we, input logic wa, input logic [7:0] wd,
                      input logic rs, input logic ra, input logic [2:0] ev);
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd;
    rd_stb = rs; rd_addr = ra;
    evt_periodic = ev[2]; evt_alarm = ev[1]; evt_update = ev[0];
    @(posedge clk);
    #(CLK_PERIOD/4);
    @(negedge clk);
    wr_en = 1'b0; rd_stb = 1'b0;
    evt_periodic = 1'b0; evt_alarm = 1'b0; evt_update = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        finish_run();
      end
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    // R1: reset state
    check("R1", "irq_n in reset", {7'b0, irq_n}, 8'h01);
    check("R1", "rd_data in reset", rd_data, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NVEC; k++) begin
      step(VECS[k].we, VECS[k].waddr, VECS[k].wdata,
           VECS[k].rs, VECS[k].raddr, VECS[k].evt);
      check("R3", $sformatf("irq_n vector %0d", k), {7'b0, irq_n}, {7'b0, VECS[k].exp_irq_n});
      check("R5", $sformatf("rd_data vector %0d", k), rd_data, VECS[k].exp_rd);
    end

    // R7: alarm already set, another alarm during the read: reported, then still set
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 3'b010);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 3'b010);
    check("R7", "read with event in window", rd_data, 8'h20);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 3'b000);
    check("R7", "deferred alarm posted", rd_data, 8'h20);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 3'b000);
    check("R6", "flags cleared by read", rd_data, 8'h00);

    // R2: two events at once while nothing is enabled
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 3'b101);
    check("R2", "irq stays high when disabled", {7'b0, irq_n}, 8'h01);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 3'b000);
    check("R8", "enable read leaves flags", rd_data, 8'h00);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 3'b000);
    check("R2", "flags set without enable", rd_data, 8'h50);

    // R4 / R9: update-ended flag first, enable after; summary bit in read
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 3'b001);
    step(1'b1, 1'b0, 8'h10, 1'b0, 1'b0, 3'b000);
    check("R4", "late enable asserts irq", {7'b0, irq_n}, 8'h00);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 3'b000);
    check("R9", "summary bit set", rd_data, 8'h90);

    // R1: reset in the middle of activity
    step(1'b1, 1'b0, 8'h70, 1'b0, 1'b0, 3'b010);
    check("R3", "alarm enabled asserts irq", {7'b0, irq_n}, 8'h00);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R1", "irq_n after mid reset", {7'b0, irq_n}, 8'h01);
    check("R1", "rd_data after mid reset", rd_data, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 3'b000);
    check("R1", "flags cleared by reset", rd_data, 8'h00);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 3'b000);
    check("R1", "enables cleared by reset", rd_data, 8'h00);

    // R10: status write with enables set keeps both registers
    step(1'b1, 1'b0, 8'h20, 1'b0, 1'b0, 3'b010);
    step(1'b1, 1'b1, 8'hFF, 1'b0, 1'b0, 3'b000);
    check("R10", "irq after status write", {7'b0, irq_n}, 8'h00);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 3'b000);
    check("R10", "enables after status write", rd_data, 8'h20);

    finish_run();
  end
endmodule